// File: doc/BRIEF.md
# USB Endpoint Handshake Responder

This block sits behind a full-speed USB token decoder. It decides how a function answers each SETUP, IN or OUT transaction on its endpoints, and it does so without any CPU involvement for IN and OUT traffic. The decoder presents one decoded token (kind plus endpoint number) as a single-cycle pulse. The block then waits for the receive or transmit phase to finish. Finally it either requests a handshake packet from the transmitter with the PID byte to send, or asks the FIFO side to transmit an IN data packet.

Each endpoint has a stall bit and a transmit-enable bit. Software sets and clears them through one-cycle write pulses. A stall always wins over every other condition for IN and OUT traffic. An IN packet goes out only when transmit-enable is set. An OUT packet is acknowledged only when the FIFO reports a complete packet. After an IN packet is sent, the host's reply sorts the transfer into success or failure. The outcome is recorded in sticky per-endpoint and global flags, and transmit-enable clears itself on success. A good SETUP on endpoint 0 is always acknowledged. It clears that endpoint's stall bit, raises the setup-received and endpoint-0-OUT-data flags, and can interrupt the CPU.

The sequencer is a four-state machine:
- ST_IDLE waits for a token.
- ST_RX_WAIT waits for the end of an OUT or SETUP data packet.
- ST_TX_WAIT waits for the IN data packet to finish leaving.
- ST_HOST_WAIT waits a bounded turnaround time for the host's handshake.

The transitions are:
- IDLE to RX_WAIT on an OUT token, or on a SETUP token addressed to endpoint 0.
- IDLE to TX_WAIT on an IN token to an unstalled, enabled endpoint.
- RX_WAIT to IDLE at the end of the data packet.
- TX_WAIT to HOST_WAIT when transmission is done.
- HOST_WAIT to IDLE when the host replies or the turnaround time expires.

Every other token seen in IDLE is either answered at once (STALL or NAK) or dropped, and the machine stays in IDLE.

Top module: `usb_ep_responder`

## Requirements
- R1: After reset, every stall bit, transmit-enable bit and status flag is 0, irq is 0, and no handshake or transmit request is issued.
- R2: An IN or OUT transaction on an endpoint whose stall bit is 1 is answered with the STALL PID byte 8'h1E, whatever the other conditions are, and no data packet is requested.
- R3: An IN token on an unstalled endpoint raises tx_req with tx_ep equal to that endpoint when its transmit-enable bit is 1. Otherwise it is answered with the NAK PID byte 8'h5A.
- R4: An OUT transaction on an unstalled endpoint is answered with the ACK PID byte 8'hD2 when rx_ok is 1 at rx_end, and with NAK 8'h5A otherwise.
- R5: A SETUP on endpoint 0 whose data arrived complete (rx_ok=1) is answered with ACK even when endpoint 0 is stalled. It clears stall bit 0 and sets the setup flag (status bit 2) and the endpoint-0 OUT-data flag (status bit 3). A SETUP on another endpoint, or one with rx_ok=0, produces no handshake and changes no flag.
- R6: When the host answers a sent IN packet with an ACK no later than TA_CYCLES clock edges after tx_done was sampled, the block sets ok_ep for that endpoint and global success (status bit 0), and clears that endpoint's transmit-enable bit.
- R7: When the host answers a sent IN packet with a non-ACK handshake, or not at all within TA_CYCLES edges, the block sets fail_ep for that endpoint and global failure (status bit 1), and transmit-enable stays set.
- R8: Every status flag stays at 1 until software pulses its clear bit. Stall and transmit-enable bits change only through their set and clear pulses and the automatic clears of R5 and R6. A set and a clear of the same bit in the same cycle leave it at 1.
- R9: irq is 1 exactly while some status bit i is 1 with irq_en[i] = 1 (bit 0 success, 1 failure, 2 setup, 3 endpoint-0 OUT data).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_valid | input | 1 | One-cycle pulse: a decoded token is present |
| tok_kind | input | 2 | Token kind: 0 OUT, 1 IN, 2 SETUP |
| tok_ep | input | EPW | Endpoint addressed by the token |
| rx_end | input | 1 | Pulse: the OUT/SETUP data packet has ended |
| rx_ok | input | 1 | Qualifies rx_end: the FIFO holds the whole packet |
| tx_done | input | 1 | Pulse: the IN data packet has been transmitted |
| host_hs_valid | input | 1 | Pulse: a handshake from the host was decoded |
| host_hs_ack | input | 1 | Qualifies host_hs_valid: the handshake was ACK |
| stall_set | input | NUM_EP | Software pulse: set stall bits |
| stall_clr | input | NUM_EP | Software pulse: clear stall bits |
| txen_set | input | NUM_EP | Software pulse: set transmit-enable bits |
| txen_clr | input | NUM_EP | Software pulse: clear transmit-enable bits |
| ok_clr | input | NUM_EP | Software pulse: clear per-endpoint success flags |
| fail_clr | input | NUM_EP | Software pulse: clear per-endpoint failure flags |
| glb_clr | input | 4 | Software pulse: clear global status bits |
| irq_en | input | 4 | Interrupt enables for the global status bits |
| hs_req | output | 1 | One-cycle request to transmit a handshake packet |
| hs_pid | output | 8 | PID byte to transmit with hs_req |
| tx_req | output | 1 | One-cycle request to transmit an IN data packet |
| tx_ep | output | EPW | Endpoint whose FIFO supplies the IN packet |
| stall_q | output | NUM_EP | Current stall bits |
| txen_q | output | NUM_EP | Current transmit-enable bits |
| ok_ep | output | NUM_EP | Sticky per-endpoint IN success flags |
| fail_ep | output | NUM_EP | Sticky per-endpoint IN failure flags |
| glb_flags | output | 4 | Sticky global status: success, failure, setup, EP0 OUT data |
| irq | output | 1 | Interrupt request |

## Verification
The responder is driven with streams of tokens of every kind, on every endpoint. The streams are mixed with random stall, transmit-enable and clear writes, so that stall and enable combinations are tried on both IN and OUT paths. Those combinations separate the stall-first priority from the enable-gated NAK and the receive-gated NAK. Host replies vary between ACK at a random delay, ACK on the last edge of the turnaround window, a non-ACK handshake and silence. These tell success apart from both kinds of failure and confirm that transmit-enable clears only on success. Directed cases cover a SETUP on a stalled endpoint 0, a SETUP on a non-zero endpoint or with an incomplete packet, simultaneous set and clear pulses, and the interrupt mask.

// File: rtl/usb_hs_pkg.sv
package usb_hs_pkg;

    typedef enum logic [1:0] {
        TK_OUT   = 2'd0,
        TK_IN    = 2'd1,
        TK_SETUP = 2'd2
    } tok_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RX_WAIT,
        ST_TX_WAIT,
        ST_HOST_WAIT
    } txn_state_e;

    // PID byte: code in the low nibble, its complement in the high nibble
    localparam logic [7:0] PID_ACK   = 8'hD2;
    localparam logic [7:0] PID_NAK   = 8'h5A;
    localparam logic [7:0] PID_STALL = 8'h1E;

    // global status bit positions
    localparam int GF_OK    = 0;
    localparam int GF_FAIL  = 1;
    localparam int GF_SETUP = 2;
    localparam int GF_EP0RX = 3;
    localparam int GF_NUM   = 4;

endpackage

// File: rtl/usb_hs_seq.sv
module usb_hs_seq
    import usb_hs_pkg::*;
#(
    parameter int NUM_EP    = 4,
    parameter int TA_CYCLES = 16,
    localparam int EPW      = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
    localparam int CW       = $clog2(TA_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_valid,
    input  logic [1:0]        tok_kind,
    input  logic [EPW-1:0]    tok_ep,
    input  logic              rx_end,
    input  logic              rx_ok,
    input  logic              tx_done,
    input  logic              host_hs_valid,
    input  logic              host_hs_ack,
    input  logic [NUM_EP-1:0] stall_q,
    input  logic [NUM_EP-1:0] txen_q,
    output logic              hs_req,
    output logic [7:0]        hs_pid,
    output logic              tx_req,
    output logic [EPW-1:0]    tx_ep,
    output logic              ev_setup_ok,
    output logic              ev_in_ok,
    output logic              ev_in_fail,
    output logic [EPW-1:0]    ev_ep
);

    txn_state_e state, nxt;
    tok_kind_e  cur_kind, tok_k;
    logic [EPW-1:0] cur_ep;
    logic [CW-1:0]  ta_cnt;
    logic           latch_tok;

    logic           resp_go;
    logic [7:0]     resp_pid;
    logic           send_go;
    logic           ta_last;

    assign tok_k   = tok_kind_e'(tok_kind);
    assign ta_last = (ta_cnt == CW'(TA_CYCLES - 1));
    assign ev_ep   = cur_ep;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // transition and decision logic
    always_comb begin
        nxt         = state;
        resp_go     = 1'b0;
        resp_pid    = PID_NAK;
        send_go     = 1'b0;
        latch_tok   = 1'b0;
        ev_setup_ok = 1'b0;
        ev_in_ok    = 1'b0;
        ev_in_fail  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (tok_valid) begin
                    latch_tok = 1'b1;
                    unique case (tok_k)
                        TK_IN: begin
                            if (stall_q[tok_ep]) begin
                                resp_go  = 1'b1;
                                resp_pid = PID_STALL;
                            end else if (txen_q[tok_ep]) begin
                                send_go = 1'b1;
                                nxt     = ST_TX_WAIT;
                            end else begin
                                resp_go  = 1'b1;
                                resp_pid = PID_NAK;
                            end
                        end
                        TK_OUT: begin
                            nxt = ST_RX_WAIT;
                        end
                        TK_SETUP: begin
                            if (tok_ep == '0) begin
                                nxt = ST_RX_WAIT;
                            end
                        end
                        default: begin
                            nxt = ST_IDLE;
                        end
                    endcase
                end
            end
            ST_RX_WAIT: begin
                if (rx_end) begin
                    nxt = ST_IDLE;
                    if (cur_kind == TK_SETUP) begin
                        if (rx_ok) begin
                            resp_go     = 1'b1;
                            resp_pid    = PID_ACK;
                            ev_setup_ok = 1'b1;
                        end
                    end else if (stall_q[cur_ep]) begin
                        resp_go  = 1'b1;
                        resp_pid = PID_STALL;
                    end else begin
                        resp_go  = 1'b1;
                        resp_pid = rx_ok ? PID_ACK : PID_NAK;
                    end
                end
            end
            ST_TX_WAIT: begin
                if (tx_done) begin
                    nxt = ST_HOST_WAIT;
                end
            end
            ST_HOST_WAIT: begin
                if (host_hs_valid) begin
                    nxt        = ST_IDLE;
                    ev_in_ok   = host_hs_ack;
                    ev_in_fail = !host_hs_ack;
                end else if (ta_last) begin
                    nxt        = ST_IDLE;
                    ev_in_fail = 1'b1;
                end
            end
            default: begin
                nxt = ST_IDLE;
            end
        endcase
    end

    // registered outputs, token context and turnaround counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_req   <= 1'b0;
            hs_pid   <= PID_NAK;
            tx_req   <= 1'b0;
            tx_ep    <= '0;
            cur_ep   <= '0;
            cur_kind <= TK_OUT;
            ta_cnt   <= '0;
        end else begin
            hs_req <= resp_go;
            tx_req <= send_go;
            if (resp_go) begin
                hs_pid <= resp_pid;
            end
            if (send_go) begin
                tx_ep <= tok_ep;
            end
            if (latch_tok) begin
                cur_ep   <= tok_ep;
                cur_kind <= tok_k;
            end
            if (state == ST_HOST_WAIT) begin
                ta_cnt <= ta_cnt + 1'b1;
            end else begin
                ta_cnt <= '0;
            end
        end
    end

    // R2
    stall_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && tok_valid && tok_k == TK_IN && stall_q[tok_ep])
        |=> (hs_req && hs_pid == PID_STALL && !tx_req));

    // R3
    nak_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && tok_valid && tok_k == TK_IN && !stall_q[tok_ep] && !txen_q[tok_ep])
        |=> (hs_req && hs_pid == PID_NAK));

    // R3
    one_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_req && tx_req));

    // R7
    ta_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOST_WAIT) |-> (ta_cnt < CW'(TA_CYCLES)));

endmodule

// File: rtl/usb_ep_ctrl.sv
module usb_ep_ctrl #(
    parameter int NUM_EP = 4,
    localparam int EPW   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EP-1:0] stall_set,
    input  logic [NUM_EP-1:0] stall_clr,
    input  logic [NUM_EP-1:0] txen_set,
    input  logic [NUM_EP-1:0] txen_clr,
    input  logic              ev_setup_ok,
    input  logic              ev_in_ok,
    input  logic [EPW-1:0]    ev_ep,
    output logic [NUM_EP-1:0] stall_q,
    output logic [NUM_EP-1:0] txen_q
);

    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        logic stall_auto_clr;
        logic txen_auto_clr;

        assign stall_auto_clr = (i == 0) && ev_setup_ok;
        assign txen_auto_clr  = ev_in_ok && (ev_ep == EPW'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stall_q[i] <= 1'b0;
            end else if (stall_set[i]) begin
                stall_q[i] <= 1'b1;
            end else if (stall_clr[i] || stall_auto_clr) begin
                stall_q[i] <= 1'b0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                txen_q[i] <= 1'b0;
            end else if (txen_set[i]) begin
                txen_q[i] <= 1'b1;
            end else if (txen_clr[i] || txen_auto_clr) begin
                txen_q[i] <= 1'b0;
            end
        end
    end

    // R5
    setup_unstall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_setup_ok && !stall_set[0]) |=> !stall_q[0]);

    // R6
    txen_autoclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_in_ok && !txen_set[ev_ep]) |=> !txen_q[$past(ev_ep)]);

endmodule

// File: rtl/usb_hs_flags.sv
module usb_hs_flags
    import usb_hs_pkg::*;
#(
    parameter int NUM_EP = 4,
    localparam int EPW   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_setup_ok,
    input  logic              ev_in_ok,
    input  logic              ev_in_fail,
    input  logic [EPW-1:0]    ev_ep,
    input  logic [NUM_EP-1:0] ok_clr,
    input  logic [NUM_EP-1:0] fail_clr,
    input  logic [GF_NUM-1:0] glb_clr,
    input  logic [GF_NUM-1:0] irq_en,
    output logic [NUM_EP-1:0] ok_ep,
    output logic [NUM_EP-1:0] fail_ep,
    output logic [GF_NUM-1:0] glb_flags,
    output logic              irq
);

    logic [GF_NUM-1:0] glb_set;

    always_comb begin
        glb_set           = '0;
        glb_set[GF_OK]    = ev_in_ok;
        glb_set[GF_FAIL]  = ev_in_fail;
        glb_set[GF_SETUP] = ev_setup_ok;
        glb_set[GF_EP0RX] = ev_setup_ok;
    end

    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        logic hit;
        assign hit = (ev_ep == EPW'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ok_ep[i]   <= 1'b0;
                fail_ep[i] <= 1'b0;
            end else begin
                if (ev_in_ok && hit) begin
                    ok_ep[i] <= 1'b1;
                end else if (ok_clr[i]) begin
                    ok_ep[i] <= 1'b0;
                end
                if (ev_in_fail && hit) begin
                    fail_ep[i] <= 1'b1;
                end else if (fail_clr[i]) begin
                    fail_ep[i] <= 1'b0;
                end
            end
        end

        // R8
        ok_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ok_ep[i] && !ok_clr[i]) |=> ok_ep[i]);

        // R8
        fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (fail_ep[i] && !fail_clr[i]) |=> fail_ep[i]);
    end

    for (genvar g = 0; g < GF_NUM; g++) begin : g_glb
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                glb_flags[g] <= 1'b0;
            end else if (glb_set[g]) begin
                glb_flags[g] <= 1'b1;
            end else if (glb_clr[g]) begin
                glb_flags[g] <= 1'b0;
            end
        end
    end

    assign irq = |(glb_flags & irq_en);

    // R6
    ok_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_in_ok |=> (glb_flags[GF_OK] && ok_ep[$past(ev_ep)]));

endmodule

// File: rtl/usb_ep_responder.sv
module usb_ep_responder
    import usb_hs_pkg::*;
#(
    parameter int NUM_EP    = 4,
    parameter int TA_CYCLES = 16,
    localparam int EPW      = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_valid,
    input  logic [1:0]        tok_kind,
    input  logic [EPW-1:0]    tok_ep,
    input  logic              rx_end,
    input  logic              rx_ok,
    input  logic              tx_done,
    input  logic              host_hs_valid,
    input  logic              host_hs_ack,
    input  logic [NUM_EP-1:0] stall_set,
    input  logic [NUM_EP-1:0] stall_clr,
    input  logic [NUM_EP-1:0] txen_set,
    input  logic [NUM_EP-1:0] txen_clr,
    input  logic [NUM_EP-1:0] ok_clr,
    input  logic [NUM_EP-1:0] fail_clr,
    input  logic [3:0]        glb_clr,
    input  logic [3:0]        irq_en,
    output logic              hs_req,
    output logic [7:0]        hs_pid,
    output logic              tx_req,
    output logic [EPW-1:0]    tx_ep,
    output logic [NUM_EP-1:0] stall_q,
    output logic [NUM_EP-1:0] txen_q,
    output logic [NUM_EP-1:0] ok_ep,
    output logic [NUM_EP-1:0] fail_ep,
    output logic [3:0]        glb_flags,
    output logic              irq
);

    logic           ev_setup_ok;
    logic           ev_in_ok;
    logic           ev_in_fail;
    logic [EPW-1:0] ev_ep;

    usb_hs_seq #(
        .NUM_EP    (NUM_EP),
        .TA_CYCLES (TA_CYCLES)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .tok_valid     (tok_valid),
        .tok_kind      (tok_kind),
        .tok_ep        (tok_ep),
        .rx_end        (rx_end),
        .rx_ok         (rx_ok),
        .tx_done       (tx_done),
        .host_hs_valid (host_hs_valid),
        .host_hs_ack   (host_hs_ack),
        .stall_q       (stall_q),
        .txen_q        (txen_q),
        .hs_req        (hs_req),
        .hs_pid        (hs_pid),
        .tx_req        (tx_req),
        .tx_ep         (tx_ep),
        .ev_setup_ok   (ev_setup_ok),
        .ev_in_ok      (ev_in_ok),
        .ev_in_fail    (ev_in_fail),
        .ev_ep         (ev_ep)
    );

    usb_ep_ctrl #(
        .NUM_EP (NUM_EP)
    ) u_ep_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .stall_set   (stall_set),
        .stall_clr   (stall_clr),
        .txen_set    (txen_set),
        .txen_clr    (txen_clr),
        .ev_setup_ok (ev_setup_ok),
        .ev_in_ok    (ev_in_ok),
        .ev_ep       (ev_ep),
        .stall_q     (stall_q),
        .txen_q      (txen_q)
    );

    usb_hs_flags #(
        .NUM_EP (NUM_EP)
    ) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_setup_ok (ev_setup_ok),
        .ev_in_ok    (ev_in_ok),
        .ev_in_fail  (ev_in_fail),
        .ev_ep       (ev_ep),
        .ok_clr      (ok_clr),
        .fail_clr    (fail_clr),
        .glb_clr     (glb_clr),
        .irq_en      (irq_en),
        .ok_ep       (ok_ep),
        .fail_ep     (fail_ep),
        .glb_flags   (glb_flags),
        .irq         (irq)
    );

    // R5
    setup_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_setup_ok |=> (hs_req && hs_pid == PID_ACK && glb_flags[GF_SETUP] && glb_flags[GF_EP0RX]));

    // R7
    fail_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_in_fail |=> (glb_flags[GF_FAIL] && fail_ep[$past(ev_ep)]));

endmodule

// File: tb/tb_usb_ep_responder.sv
module tb_usb_ep_responder;

    localparam int CLK_PERIOD = 10;
    localparam int NEP        = 4;
    localparam int TA         = 8;
    localparam int EW         = 2;
    localparam logic [7:0] P_ACK = 8'hD2, P_NAK = 8'h5A, P_STALL = 8'h1E;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tok_valid = 0, rx_end = 0, rx_ok = 0, tx_done = 0;
    logic host_hs_valid = 0, host_hs_ack = 0;
    logic [1:0] tok_kind = 0;
    logic [EW-1:0] tok_ep = 0;
    logic [NEP-1:0] stall_set = 0, stall_clr = 0, txen_set = 0, txen_clr = 0;
    logic [NEP-1:0] ok_clr = 0, fail_clr = 0;
    logic [3:0] glb_clr = 0, irq_en = 0;
    logic hs_req, tx_req, irq;
    logic [7:0] hs_pid;
    logic [EW-1:0] tx_ep;
    logic [NEP-1:0] stall_q, txen_q, ok_ep, fail_ep;
    logic [3:0] glb_flags;

    usb_ep_responder #(.NUM_EP(NEP), .TA_CYCLES(TA)) dut (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_kind(tok_kind),
        .tok_ep(tok_ep), .rx_end(rx_end), .rx_ok(rx_ok), .tx_done(tx_done),
        .host_hs_valid(host_hs_valid), .host_hs_ack(host_hs_ack),
        .stall_set(stall_set), .stall_clr(stall_clr), .txen_set(txen_set),
        .txen_clr(txen_clr), .ok_clr(ok_clr), .fail_clr(fail_clr),
        .glb_clr(glb_clr), .irq_en(irq_en), .hs_req(hs_req), .hs_pid(hs_pid),
        .tx_req(tx_req), .tx_ep(tx_ep), .stall_q(stall_q), .txen_q(txen_q),
        .ok_ep(ok_ep), .fail_ep(fail_ep), .glb_flags(glb_flags), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_vec = 0, n_bad = 0;
    int hs_cnt = 0, tx_cnt = 0;
    logic [7:0] last_pid = 0;
    logic [EW-1:0] last_txep = 0;

    // reference state
    logic [NEP-1:0] m_stall = 0, m_txen = 0, m_ok = 0, m_fail = 0;
    logic [3:0] m_glb = 0;

    always @(negedge clk) begin
        if (hs_req) begin hs_cnt++; last_pid = hs_pid; end
        if (tx_req) begin tx_cnt++; last_txep = tx_ep; end
    end

    task automatic chk(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic exp_irq(logic [3:0] g, logic [3:0] en);
        return |(g & en);
    endfunction

    task automatic chk_state(string req);
        chk({req, " stall"}, int'(stall_q), int'(m_stall));
        chk({req, " txen"},  int'(txen_q),  int'(m_txen));
        chk({req, " ok"},    int'(ok_ep),   int'(m_ok));
        chk({req, " fail"},  int'(fail_ep), int'(m_fail));
        chk({req, " glb"},   int'(glb_flags), int'(m_glb));
        chk("R9 irq", int'(irq), int'(exp_irq(m_glb, irq_en)));
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // one-cycle software write; set beats clear
    task automatic cpu_write(logic [NEP-1:0] ss, logic [NEP-1:0] sc, logic [NEP-1:0] ts,
                             logic [NEP-1:0] tc, logic [NEP-1:0] oc, logic [NEP-1:0] fc,
                             logic [3:0] gc);
        stall_set = ss; stall_clr = sc; txen_set = ts; txen_clr = tc;
        ok_clr = oc; fail_clr = fc; glb_clr = gc;
        @(negedge clk);
        stall_set = 0; stall_clr = 0; txen_set = 0; txen_clr = 0;
        ok_clr = 0; fail_clr = 0; glb_clr = 0;
        m_stall = (m_stall & ~sc) | ss;
        m_txen  = (m_txen & ~tc) | ts;
        m_ok    = m_ok & ~oc;
        m_fail  = m_fail & ~fc;
        m_glb   = m_glb & ~gc;
        chk_state("R8");
    endtask

    // mode: 0 host ACK, 1 host non-ACK, 2 silence; dly: edges before ACK
    task automatic do_txn(logic [1:0] kind, logic [EW-1:0] ep, logic ok, int mode, int dly);
        int exp_hs = 0, exp_tx = 0;
        logic [7:0] exp_pid = 0;
        string tag = "R3";
        hs_cnt = 0; tx_cnt = 0;
        case (kind)
            2'd2: begin
                tag = "R5";
                if (ep == 0 && ok) begin
                    exp_hs = 1; exp_pid = P_ACK;
                    m_glb[2] = 1; m_glb[3] = 1; m_stall[0] = 0;
                end
            end
            2'd0: begin
                exp_hs = 1;
                if (m_stall[ep]) begin tag = "R2"; exp_pid = P_STALL; end
                else begin tag = "R4"; exp_pid = ok ? P_ACK : P_NAK; end
            end
            default: begin
                if (m_stall[ep]) begin tag = "R2"; exp_hs = 1; exp_pid = P_STALL; end
                else if (m_txen[ep]) begin
                    exp_tx = 1;
                    if (mode == 0) begin
                        tag = "R6"; m_ok[ep] = 1; m_glb[0] = 1; m_txen[ep] = 0;
                    end else begin
                        tag = "R7"; m_fail[ep] = 1; m_glb[1] = 1;
                    end
                end else begin tag = "R3"; exp_hs = 1; exp_pid = P_NAK; end
            end
        endcase
        tok_valid = 1; tok_kind = kind; tok_ep = ep;
        @(negedge clk);
        tok_valid = 0;
        if (kind != 2'd1) begin
            cyc(1);
            rx_end = 1; rx_ok = ok;
            @(negedge clk);
            rx_end = 0; rx_ok = 0;
        end else if (exp_tx == 1) begin
            cyc(1);
            tx_done = 1;
            @(negedge clk);
            tx_done = 0;
            if (mode == 2) cyc(TA + 2);
            else begin
                cyc(dly);
                host_hs_valid = 1; host_hs_ack = (mode == 0);
                @(negedge clk);
                host_hs_valid = 0; host_hs_ack = 0;
            end
        end
        cyc(2);
        chk({tag, " hs count"}, hs_cnt, exp_hs);
        if (exp_hs == 1) chk({tag, " pid"}, int'(last_pid), int'(exp_pid));
        chk({tag, " tx count"}, tx_cnt, exp_tx);
        if (exp_tx == 1) chk("R3 tx_ep", int'(last_txep), int'(ep));
        chk_state(tag);
    endtask

    initial begin
        void'($urandom(32'd1234));
        cyc(3);
        // R1 reset state
        chk("R1 hs_req", int'(hs_req), 0);
        chk("R1 tx_req", int'(tx_req), 0);
        chk_state("R1");
        rst_n = 1'b1;
        cyc(2);
        chk_state("R1");

        // R2: stall wins over transmit-enable and over a complete OUT
        cpu_write(4'b0010, 0, 4'b0010, 0, 0, 0, 0);
        do_txn(2'd1, 2'd1, 1'b1, 0, 0);
        do_txn(2'd0, 2'd1, 1'b1, 0, 0);
        // R5: SETUP on stalled EP0 acked and unstalls; bad SETUPs ignored
        cpu_write(4'b0001, 0, 0, 0, 0, 0, 0);
        do_txn(2'd2, 2'd0, 1'b1, 0, 0);
        do_txn(2'd2, 2'd2, 1'b1, 0, 0);
        do_txn(2'd2, 2'd0, 1'b0, 0, 0);
        // R4 both answers
        do_txn(2'd0, 2'd3, 1'b1, 0, 0);
        do_txn(2'd0, 2'd3, 1'b0, 0, 0);
        // R6: host ACK on the last edge of the window
        cpu_write(0, 0, 4'b0100, 0, 0, 0, 0);
        do_txn(2'd1, 2'd2, 1'b0, 0, TA - 1);
        // R3: enable cleared, so NAK now
        do_txn(2'd1, 2'd2, 1'b0, 0, 0);
        // R7: silence and non-ACK
        cpu_write(0, 0, 4'b1000, 0, 0, 0, 0);
        do_txn(2'd1, 2'd3, 1'b0, 2, 0);
        do_txn(2'd1, 2'd3, 1'b0, 1, 2);
        // R8: simultaneous set and clear keep the bit
        cpu_write(4'b0100, 4'b0100, 4'b0001, 4'b0001, 0, 0, 0);
        cpu_write(0, 4'b1111, 0, 4'b1111, 4'b1111, 4'b1111, 4'b1111);
        // R9: mask walk
        do_txn(2'd2, 2'd0, 1'b1, 0, 0);
        for (int b = 0; b < 4; b++) begin
            irq_en = 4'(1 << b);
            cyc(1);
            chk("R9 mask", int'(irq), int'(exp_irq(m_glb, irq_en)));
        end

        // random traffic
        for (int n = 0; n < 400; n++) begin
            int r = $urandom_range(0, 9);
            irq_en = 4'($urandom);
            if (r < 3) begin
                logic [NEP-1:0] a = NEP'($urandom), b = NEP'($urandom);
                cpu_write(a & NEP'($urandom), b & NEP'($urandom),
                          NEP'($urandom), NEP'($urandom) & NEP'($urandom),
                          NEP'($urandom), NEP'($urandom), 4'($urandom));
            end else begin
                logic [1:0] k = 2'($urandom_range(0, 2));
                do_txn(k, EW'($urandom), 1'($urandom), $urandom_range(0, 2),
                       $urandom_range(0, TA - 1));
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule